// File: doc/BRIEF.md
# CAN FD Transmitter Delay Compensation Unit

This unit lets a CAN FD transmitter keep checking its own bits when the data-phase bit time is shorter than the loop through the transceiver. On every frame that is sent with a bit-rate switch and with compensation enabled, it counts protocol-engine clock cycles from the dominant edge that the transmitter puts on its TX line at the EDL-to-R0 boundary until the same edge comes back on RX. It adds a programmable offset to this count, clamps the result to 63 and keeps it as the compensation value.

During the data phase, which runs from the sample point of the BRS bit to the sample point of the CRC delimiter, each transmitted bit is checked at a secondary sample point. That point lies the compensation value in cycles after the start of the bit. There the received bit is compared with a copy of the TX line delayed by the same number of cycles, and any mismatch gives a one-cycle error pulse. The protocol engine supplies the bit-start and sample-point strobes. Bit timing, arbitration and error signalling stay in the protocol engine.

Top module: `tdc_unit`

## Requirements
- R1: After reset, `tdc_value` is 0 and `bit_error` is 0.
- R2: A frame is qualified when `tdc_en`, `fd_frame` and `brs_frame` are all 1 in the `edl_arm` cycle. An unqualified frame leaves `tdc_value` unchanged and never produces `bit_error`.
- R3: Line level 1 is recessive and 0 is dominant. Let d be the number of cycles from the first cycle with TX low after the `edl_arm` strobe to the first cycle with RX low. On a qualified frame, `tdc_value` becomes d + `tdc_offset` at the clock edge where RX is first sampled low. The count restarts at every `edl_arm`.
- R4: When d + `tdc_offset` exceeds 63, `tdc_value` becomes 63.
- R5: If RX has not gone low by the `r0_sp` strobe, `tdc_value` becomes 63 at that edge. If RX goes low in the same cycle as `r0_sp`, the measured value is used.
- R6: The checking window opens at a `brs_sp` strobe of a qualified frame and closes at a `crcdel_sp` strobe. If both strobes arrive in the same cycle, closing wins.
- R7: Take a bit whose `bit_start` strobe falls in cycle S while the window is open. Let V be the value of `tdc_value`. `bit_error` is high for exactly the cycle after cycle S+V if RX in cycle S+V differs from TX in cycle S.
- R8: A bit whose `bit_start` comes before the window opens, or comes while `in_crc_del` is 1, is never checked, so its RX value cannot raise `bit_error`.
- R9: `tdc_value` changes only as the result of a measurement. It is held across unqualified frames and until the next qualified one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Protocol-engine clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_bit | input | 1 | Transmitted bus level (1 recessive) |
| rx_bit | input | 1 | Received bus level (1 recessive) |
| edl_arm | input | 1 | One-cycle strobe during the EDL bit; arms and clears the measurement |
| r0_sp | input | 1 | Sample-point strobe of the R0 bit; ends an unfinished measurement |
| brs_sp | input | 1 | Sample-point strobe of the BRS bit; opens the window |
| crcdel_sp | input | 1 | Sample-point strobe of the CRC delimiter; closes the window |
| bit_start | input | 1 | One-cycle strobe at the first cycle of each transmitted bit |
| in_crc_del | input | 1 | High throughout the CRC delimiter bit |
| fd_frame | input | 1 | Current frame uses the FD format |
| brs_frame | input | 1 | Current frame switches bit rate |
| tdc_en | input | 1 | Compensation enable |
| tdc_offset | input | 6 | Offset added to the measured delay |
| tdc_value | output | 6 | Saturated compensation value |
| bit_error | output | 1 | One-cycle pulse on a mismatch at a secondary sample point |

## Verification
The bench runs frames with a loop delay longer than the data bit time. A unit that compared against the current TX bit would then report a mismatch on almost every bit, so the counted error pulses would exceed the injected ones. It tests the clamp on a large offset and the timeout when the returning edge arrives after the R0 sample point. A missing clamp would show a wrapped small value, and a missing timeout would leave the old value in place. It corrupts RX during the BRS bit and the CRC delimiter, where a design with a wrong window or without the delimiter exclusion would pulse. It also sends unqualified frames between qualified ones, where a value that is not held, or a measurement that is not restarted, would change the stored result.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

   typedef enum logic [1:0] {
      MS_IDLE  = 2'd0,
      MS_ARMED = 2'd1,
      MS_COUNT = 2'd2
   } meas_st_e;

endpackage

// File: rtl/tdc_loop_meas.sv
module tdc_loop_meas
   import tdc_pkg::*;
#(
   parameter int VAL_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             qualify,
   input  logic             tx_bit,
   input  logic             rx_bit,
   input  logic             r0_sp,
   input  logic [VAL_W-1:0] offset,
   output logic [VAL_W-1:0] value
);
   localparam logic [VAL_W-1:0] VAL_MAX = {VAL_W{1'b1}};

   meas_st_e         st_q;
   logic [VAL_W-1:0] cnt_q;
   logic [VAL_W-1:0] value_q;
   logic             tx_prev_q, rx_prev_q;
   logic             tx_fall, rx_fall;
   logic [VAL_W:0]   sum_cnt, sum_zero;
   logic [VAL_W-1:0] clamp_cnt, clamp_zero;

   assign tx_fall = tx_prev_q & ~tx_bit;
   assign rx_fall = rx_prev_q & ~rx_bit;

   assign sum_cnt    = {1'b0, cnt_q} + {1'b0, offset};
   assign sum_zero   = {1'b0, offset};
   assign clamp_cnt  = sum_cnt[VAL_W]  ? VAL_MAX : sum_cnt[VAL_W-1:0];
   assign clamp_zero = sum_zero[VAL_W] ? VAL_MAX : sum_zero[VAL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_prev_q <= 1'b1;
         rx_prev_q <= 1'b1;
      end else begin
         tx_prev_q <= tx_bit;
         rx_prev_q <= rx_bit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= MS_IDLE;
         cnt_q   <= '0;
         value_q <= '0;
      end else if (arm) begin
         st_q  <= qualify ? MS_ARMED : MS_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            MS_ARMED: begin
               if (tx_fall && rx_fall) begin
                  value_q <= clamp_zero;
                  st_q    <= MS_IDLE;
               end else if (tx_fall) begin
                  cnt_q <= {{(VAL_W-1){1'b0}}, 1'b1};
                  st_q  <= MS_COUNT;
               end else if (r0_sp) begin
                  st_q <= MS_IDLE;
               end
            end
            MS_COUNT: begin
               if (rx_fall) begin
                  value_q <= clamp_cnt;
                  st_q    <= MS_IDLE;
               end else if (r0_sp) begin
                  value_q <= VAL_MAX;
                  st_q    <= MS_IDLE;
               end else if (cnt_q != VAL_MAX) begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: st_q <= MS_IDLE;
         endcase
      end
   end

   assign value = value_q;

   p_value_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(value_q) |-> $past(st_q != MS_IDLE));

   p_timeout_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == MS_COUNT && !arm && r0_sp && !rx_fall) |=> (value_q == VAL_MAX));

endmodule

// File: rtl/tdc_delay_line.sv
module tdc_delay_line #(
   parameter int VAL_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_bit,
   input  logic             strobe_in,
   input  logic [VAL_W-1:0] sel,
   output logic             tx_tap,
   output logic             strobe_tap
);
   localparam int DEPTH = 1 << VAL_W;

   logic [DEPTH-1:0] tx_vec;
   logic [DEPTH-1:0] st_vec;

   assign tx_vec[0] = tx_bit;
   assign st_vec[0] = strobe_in;

   for (genvar stage = 1; stage < DEPTH; stage++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tx_vec[stage] <= 1'b1;
            st_vec[stage] <= 1'b0;
         end else begin
            tx_vec[stage] <= tx_vec[stage-1];
            st_vec[stage] <= st_vec[stage-1];
         end
      end
   end

   assign tx_tap     = tx_vec[sel];
   assign strobe_tap = st_vec[sel];

endmodule

// File: rtl/tdc_bit_check.sv
module tdc_bit_check (
   input  logic clk,
   input  logic rst_n,
   input  logic comp_ok,
   input  logic brs_sp,
   input  logic crcdel_sp,
   input  logic bit_start,
   input  logic in_crc_del,
   input  logic rx_bit,
   input  logic tx_tap,
   input  logic strobe_tap,
   output logic strobe_q,
   output logic bit_error
);
   logic win_q;
   logic err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= 1'b0;
      end else if (crcdel_sp) begin
         win_q <= 1'b0;
      end else if (brs_sp && comp_ok) begin
         win_q <= 1'b1;
      end
   end

   assign strobe_q = bit_start & win_q & ~in_crc_del;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else begin
         err_q <= strobe_tap & (rx_bit ^ tx_tap);
      end
   end

   assign bit_error = err_q;

   p_win_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
      crcdel_sp |=> !win_q);

   p_win_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_q) |-> $past(brs_sp && comp_ok));

endmodule

// File: rtl/tdc_unit.sv
module tdc_unit #(
   parameter int VAL_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_bit,
   input  logic             rx_bit,
   input  logic             edl_arm,
   input  logic             r0_sp,
   input  logic             brs_sp,
   input  logic             crcdel_sp,
   input  logic             bit_start,
   input  logic             in_crc_del,
   input  logic             fd_frame,
   input  logic             brs_frame,
   input  logic             tdc_en,
   input  logic [VAL_W-1:0] tdc_offset,
   output logic [VAL_W-1:0] tdc_value,
   output logic             bit_error
);
   if (VAL_W < 2 || VAL_W > 8) begin : g_bad_width
      $error("tdc_unit: VAL_W must lie between 2 and 8");
   end

   logic             comp_ok;
   logic             strobe_q, strobe_tap, tx_tap;
   logic [VAL_W-1:0] value;

   assign comp_ok = tdc_en & fd_frame & brs_frame;

   tdc_loop_meas #(.VAL_W(VAL_W)) u_meas (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (edl_arm),
      .qualify (comp_ok),
      .tx_bit  (tx_bit),
      .rx_bit  (rx_bit),
      .r0_sp   (r0_sp),
      .offset  (tdc_offset),
      .value   (value)
   );

   tdc_delay_line #(.VAL_W(VAL_W)) u_dline (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_bit     (tx_bit),
      .strobe_in  (strobe_q),
      .sel        (value),
      .tx_tap     (tx_tap),
      .strobe_tap (strobe_tap)
   );

   tdc_bit_check u_check (
      .clk        (clk),
      .rst_n      (rst_n),
      .comp_ok    (comp_ok),
      .brs_sp     (brs_sp),
      .crcdel_sp  (crcdel_sp),
      .bit_start  (bit_start),
      .in_crc_del (in_crc_del),
      .rx_bit     (rx_bit),
      .tx_tap     (tx_tap),
      .strobe_tap (strobe_tap),
      .strobe_q   (strobe_q),
      .bit_error  (bit_error)
   );

   assign tdc_value = value;

   p_err_needs_ssp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bit_error |-> $past(strobe_tap));

   p_no_ssp_in_delim_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_crc_del |-> !strobe_q);

endmodule

// File: tb/tdc_unit_bench.sv
module tdc_unit_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_bit = 1'b1, rx_bit = 1'b1;
   logic       edl_arm = 0, r0_sp = 0, brs_sp = 0, crcdel_sp = 0;
   logic       bit_start = 0, in_crc_del = 0;
   logic       fd_frame = 0, brs_frame = 0, tdc_en = 0;
   logic [5:0] tdc_offset = '0;
   logic [5:0] tdc_value;
   logic       bit_error;

   int checks = 0, errors = 0, pulses = 0, loopd = 0;
   string cur_req = "R1";
   logic txh[$];
   logic flh[$];

   // behavioural reference model state
   int   m_tdc = 0, m_cnt = 0, m_st = 0;
   logic m_win = 0, m_err = 0, m_txp = 1, m_rxp = 1;
   logic mtx[$];
   logic mst[$];

   always #10 clk = ~clk;

   tdc_unit u_tdc_unit (
      .clk(clk), .rst_n(rst_n), .tx_bit(tx_bit), .rx_bit(rx_bit),
      .edl_arm(edl_arm), .r0_sp(r0_sp), .brs_sp(brs_sp), .crcdel_sp(crcdel_sp),
      .bit_start(bit_start), .in_crc_del(in_crc_del), .fd_frame(fd_frame),
      .brs_frame(brs_frame), .tdc_en(tdc_en), .tdc_offset(tdc_offset),
      .tdc_value(tdc_value), .bit_error(bit_error)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_tdc = 0; m_cnt = 0; m_st = 0; m_win = 0; m_err = 0;
         m_txp = 1; m_rxp = 1; mtx.delete(); mst.delete();
      end else begin
         logic q, txf, rxf, e_n, ok;
         q  = bit_start && m_win && !in_crc_del;
         ok = tdc_en && fd_frame && brs_frame;
         mtx.push_front(tx_bit);
         mst.push_front(q);
         if (mtx.size() > 64) begin void'(mtx.pop_back()); void'(mst.pop_back()); end
         e_n = (m_tdc < mst.size()) ? (mst[m_tdc] && (rx_bit != mtx[m_tdc])) : 1'b0;
         txf = m_txp && !tx_bit;
         rxf = m_rxp && !rx_bit;
         if (edl_arm) begin
            m_st = ok ? 1 : 0; m_cnt = 0;
         end else if (m_st == 1) begin
            if (txf && rxf) begin m_tdc = (tdc_offset > 63) ? 63 : tdc_offset; m_st = 0; end
            else if (txf) begin m_cnt = 1; m_st = 2; end
            else if (r0_sp) m_st = 0;
         end else if (m_st == 2) begin
            if (rxf) begin m_tdc = (m_cnt + tdc_offset > 63) ? 63 : m_cnt + tdc_offset; m_st = 0; end
            else if (r0_sp) begin m_tdc = 63; m_st = 0; end
            else if (m_cnt < 63) m_cnt = m_cnt + 1;
         end
         if (crcdel_sp) m_win = 0;
         else if (brs_sp && ok) m_win = 1;
         m_txp = tx_bit; m_rxp = rx_bit; m_err = e_n;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (tdc_value !== 6'(m_tdc)) begin
            errors++;
            $display("FAIL %s tdc_value actual=%0d expected=%0d", cur_req, tdc_value, m_tdc);
         end
         checks++;
         if (bit_error !== m_err) begin
            errors++;
            $display("FAIL %s bit_error actual=%0b expected=%0b", cur_req, bit_error, m_err);
         end
         if (bit_error === 1'b1) pulses++;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input logic t, input logic f);
      tx_bit = t;
      txh.push_front(t);
      flh.push_front(f);
      if (txh.size() > 80) begin void'(txh.pop_back()); void'(flh.pop_back()); end
      rx_bit = (txh.size() > loopd) ? (txh[loopd] ^ flh[loopd]) : 1'b1;
      @(negedge clk);
      edl_arm = 0; r0_sp = 0; brs_sp = 0; crcdel_sp = 0; bit_start = 0;
   endtask

   task automatic frame(input logic en, input logic fd, input logic brs,
                        input int off, input int ld, input logic [9:0] fmask,
                        input logic fbrs, input logic fcrc);
      logic [9:0] pat = 10'b1011001110;
      tdc_en = en; fd_frame = fd; brs_frame = brs;
      tdc_offset = 6'(off); loopd = ld;
      for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0);
      for (int i = 0; i < 16; i++) begin edl_arm = (i == 0); cyc(1'b1, 1'b0); end
      for (int i = 0; i < 16; i++) begin r0_sp = (i == 12); cyc(1'b0, 1'b0); end
      for (int i = 0; i < 16; i++) begin brs_sp = (i == 12); cyc(1'b1, fbrs); end
      for (int b = 0; b < 10; b++)
         for (int i = 0; i < 4; i++) begin bit_start = (i == 0); cyc(pat[b], fmask[b]); end
      in_crc_del = 1;
      for (int i = 0; i < 4; i++) begin
         bit_start = (i == 0); crcdel_sp = (i == 3); cyc(1'b1, fcrc);
      end
      in_crc_del = 0;
      for (int i = 0; i < 70; i++) cyc(1'b1, 1'b0);
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int p0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset tdc_value", int'(tdc_value), 0);
      check("R1 reset bit_error", int'(bit_error), 0);

      // loop delay 7 exceeds 4-cycle data bit; two corrupted data bits, plus BRS and delimiter
      cur_req = "R3"; p0 = pulses;
      frame(1, 1, 1, 2, 7, 10'b0000100100, 1'b1, 1'b1);
      check("R3 value = delay + offset", int'(tdc_value), 9);
      check("R7 pulses for corrupted data bits", pulses - p0, 2);
      check("R8 BRS and delimiter not checked", pulses - p0, 2);

      cur_req = "R2"; p0 = pulses;
      frame(1, 1, 0, 0, 3, 10'b0001000010, 1'b0, 1'b0);
      check("R2 no rate switch holds value", int'(tdc_value), 9);
      check("R2 no rate switch gives no pulse", pulses - p0, 0);

      cur_req = "R9"; p0 = pulses;
      frame(0, 1, 1, 0, 3, 10'b0001000010, 1'b0, 1'b0);
      check("R9 disabled frame holds value", int'(tdc_value), 9);
      check("R6 window stays closed when disabled", pulses - p0, 0);

      cur_req = "R7"; p0 = pulses;
      frame(1, 1, 1, 0, 2, 10'b0010000000, 1'b0, 1'b0);
      check("R3 short loop delay", int'(tdc_value), 2);
      check("R7 single corrupted bit", pulses - p0, 1);

      cur_req = "R5";
      frame(1, 1, 1, 0, 14, 10'b0, 1'b0, 1'b0);
      check("R5 timeout at R0 sample point", int'(tdc_value), 63);

      cur_req = "R3";
      frame(1, 1, 1, 1, 4, 10'b0, 1'b0, 1'b0);
      check("R3 counter restarts each frame", int'(tdc_value), 5);

      cur_req = "R4";
      frame(1, 1, 1, 60, 5, 10'b0, 1'b0, 1'b0);
      check("R4 sum clamped", int'(tdc_value), 63);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule